// File: doc/BRIEF.md
# Opportunistic Bundling Request Merger

This block joins two four-phase request/acknowledge client channels into one four-phase channel that drives a shared service, such as a common alarm, a refresh pass or a power-management step. The service, once performed, benefits every client that was waiting for it. When both clients have a request pending at the moment the output request is issued, one output transaction serves them both and both clients are acknowledged in the same cycle. A request that shows up later waits for the following output transaction.

The block is a clocked state machine. Its inputs are assumed to be clean, hazard-free handshakes. A parameter can disable bundling. In that case a round-robin priority bit orders simultaneous requests so that neither client starves.

Top module: `opp_merge`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, ack_a_o, ack_b_o and out_req_o are all 0.
- R2: With bundling enabled (ALLOW_BUNDLE=1), if both requests are pending when out_req_o is raised, one output transaction serves both, and ack_a_o and ack_b_o rise in the same cycle.
- R3: A client acknowledgement rises only if that client's request was pending when out_req_o was raised. A lone pending request is served alone.
- R4: A client acknowledgement rises one clock after out_ack_i is seen high while out_req_o is high, and never before.
- R5: Once raised, out_req_o stays high until out_ack_i is seen high, and falls on the next clock.
- R6: A client acknowledgement stays high while its request is high. It falls on the clock after its request is seen low.
- R7: out_req_o is raised only when ack_a_o, ack_b_o and out_ack_i are all low. A pending request does not start a new transaction while an earlier acknowledgement is still high.
- R8: A request that rises after out_req_o has gone high is not part of that transaction. It is served by the next output transaction.
- R9: With bundling disabled (ALLOW_BUNDLE=0), only one client is served per transaction. On a tie, the preferred client wins. Preference starts at client a (RR_INIT=0) and moves to the other client after each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_a_i | input | 1 | Client a request |
| ack_a_o | output | 1 | Client a acknowledge |
| req_b_i | input | 1 | Client b request |
| ack_b_o | output | 1 | Client b acknowledge |
| out_req_o | output | 1 | Request to the shared service |
| out_ack_i | input | 1 | Acknowledge from the shared service |

## Verification
Two functions can land in the same clock edge. The edge that clears one client's acknowledgement may also be the edge on which the other client's waiting request could start a new transaction. The bench provokes this by raising client b's request after out_req_o is already high, then dropping client a's request. It checks that out_req_o stays low on the edge where ack_a_o clears, and rises only one edge later. The tie in round-robin mode is the second collision: the bench compares the winner against a preference model that it keeps itself.

// File: rtl/omrg_pkg.sv
// Shared types for the opportunistic merger.
package omrg_pkg;
    // Output handshake phase of the controller.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_WAIT_ACK = 2'd1,
        PH_WAIT_REL = 2'd2
    } phase_t;

    localparam int NUM_CLIENTS = 2;
endpackage

// File: rtl/omrg_select.sv
// Chooses which pending clients join the next output transaction.
// Assumes pend bits are already masked by outstanding acknowledgements.
// ALLOW_BUNDLE=1: every pending client joins. ALLOW_BUNDLE=0: a tie is
// broken by pref_b (1 selects client b).
module omrg_select #(
    parameter bit ALLOW_BUNDLE = 1'b1,
    parameter int NCL          = omrg_pkg::NUM_CLIENTS
) (
    input  logic [NCL-1:0] pend,
    input  logic           pref_b,
    output logic [NCL-1:0] sel
);
    generate
        if (ALLOW_BUNDLE) begin : g_bundle
            // Bundle everything that is pending.
            always_comb sel = pend;
        end else begin : g_single
            // Serve one client; round-robin on a tie.
            always_comb begin
                sel = pend;
                if (&pend) sel = pref_b ? 2'b10 : 2'b01;
            end
        end
    endgenerate
endmodule

// File: rtl/omrg_ack_cell.sv
// One client's acknowledgement register.
// Sets when the service grants a transaction this client belongs to.
// Clears once the client's request has been seen low (four-phase return).
module omrg_ack_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic member,
    input  logic req,
    output logic ack
);
    // Set on grant for a member, clear after the request is withdrawn.
    always_ff @(posedge clk) begin
        if (!rst_n)                ack <= 1'b0;
        else if (grant && member)  ack <= 1'b1;
        else if (ack && !req)      ack <= 1'b0;
    end
endmodule

// File: rtl/omrg_ctrl.sv
// Output handshake controller. It issues out_req when something is
// selected and every acknowledgement is back at 0. It latches the
// selection as the transaction's membership and pulses grant when the
// service acknowledges. It also keeps the round-robin preference bit.
module omrg_ctrl #(
    parameter bit RR_INIT = 1'b0,
    parameter int NCL     = omrg_pkg::NUM_CLIENTS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCL-1:0] sel,
    input  logic           any_ack,
    input  logic           out_ack,
    output logic           out_req,
    output logic           grant,
    output logic [NCL-1:0] members,
    output logic           pref_b
);
    import omrg_pkg::*;

    phase_t phase;
    logic   issue;

    // Start a transaction only from idle with all handshakes returned.
    assign issue   = (phase == PH_IDLE) && (|sel) && !any_ack && !out_ack;
    assign grant   = (phase == PH_WAIT_ACK) && out_ack;
    assign out_req = (phase == PH_WAIT_ACK);

    // Phase sequencing of the output four-phase handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else begin
            case (phase)
                PH_IDLE:     if (issue)    phase <= PH_WAIT_ACK;
                PH_WAIT_ACK: if (out_ack)  phase <= PH_WAIT_REL;
                PH_WAIT_REL: if (!out_ack) phase <= PH_IDLE;
                default:                   phase <= PH_IDLE;
            endcase
        end
    end

    // Capture the membership of the transaction being issued.
    always_ff @(posedge clk) begin
        if (!rst_n)     members <= '0;
        else if (issue) members <= sel;
    end

    // Move preference away from a client served alone.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pref_b <= RR_INIT;
        else if (issue && sel == 2'b01) pref_b <= 1'b1;
        else if (issue && sel == 2'b10) pref_b <= 1'b0;
    end
endmodule

// File: rtl/opp_merge.sv
// Top of the opportunistic merger: two client four-phase channels onto
// one service channel. Assumes hazard-free client handshakes.
module opp_merge #(
    parameter bit ALLOW_BUNDLE = 1'b1,
    parameter bit RR_INIT      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a_i,
    output logic ack_a_o,
    input  logic req_b_i,
    output logic ack_b_o,
    output logic out_req_o,
    input  logic out_ack_i
);
    localparam int NCL = omrg_pkg::NUM_CLIENTS;

    logic [NCL-1:0] req_v, ack_v, pend, sel, members;
    logic           grant, pref_b;

    assign req_v = {req_b_i, req_a_i};
    assign pend  = req_v & ~ack_v;

    omrg_select #(.ALLOW_BUNDLE(ALLOW_BUNDLE), .NCL(NCL)) u_sel (
        .pend(pend), .pref_b(pref_b), .sel(sel)
    );

    omrg_ctrl #(.RR_INIT(RR_INIT), .NCL(NCL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .any_ack(|ack_v),
        .out_ack(out_ack_i), .out_req(out_req_o), .grant(grant),
        .members(members), .pref_b(pref_b)
    );

    generate
        for (genvar i = 0; i < NCL; i++) begin : g_ack
            omrg_ack_cell u_cell (
                .clk(clk), .rst_n(rst_n), .grant(grant),
                .member(members[i]), .req(req_v[i]), .ack(ack_v[i])
            );
        end
    endgenerate

    assign ack_a_o = ack_v[0];
    assign ack_b_o = ack_v[1];
endmodule

// File: rtl/omrg_chk.sv
// Protocol checker for opp_merge, bound to every instance.
module omrg_chk #(
    parameter bit ALLOW_BUNDLE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic req_a_i,
    input logic ack_a_o,
    input logic req_b_i,
    input logic ack_b_o,
    input logic out_req_o,
    input logic out_ack_i
);
    p_ack_after_oack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_a_o) || $rose(ack_b_o)) |-> $past(out_ack_i) && $past(out_req_o));
    p_ack_a_member_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_a_o) |-> $past(req_a_i));
    p_ack_b_member_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_b_o) |-> $past(req_b_i));
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req_o && !out_ack_i) |=> out_req_o);
    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req_o && out_ack_i) |=> !out_req_o);
    p_ack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_a_o && req_a_i) |=> ack_a_o) and ((ack_b_o && req_b_i) |=> ack_b_o));
    p_ack_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_a_o) |-> !$past(req_a_i)) and ($fell(ack_b_o) |-> !$past(req_b_i)));
    p_req_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req_o) |-> $past(!ack_a_o && !ack_b_o && !out_ack_i));

    generate
        if (!ALLOW_BUNDLE) begin : g_single
            p_one_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !($rose(ack_a_o) && $rose(ack_b_o)));
        end
    endgenerate
endmodule

bind opp_merge omrg_chk #(.ALLOW_BUNDLE(ALLOW_BUNDLE)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_a_i(req_a_i), .ack_a_o(ack_a_o),
    .req_b_i(req_b_i), .ack_b_o(ack_b_o), .out_req_o(out_req_o),
    .out_ack_i(out_ack_i)
);

// File: tb/opp_merge_tb.sv
module opp_merge_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ra = 0, rb = 0, oack = 0;
    logic aa, ab, oreq;
    logic ra2 = 0, rb2 = 0, oack2 = 0;
    logic aa2, ab2, oreq2;
    int   checks = 0, errors = 0;
    bit   rr_m = 1'b0;

    always #5 clk = ~clk;

    opp_merge #(.ALLOW_BUNDLE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_a_i(ra), .ack_a_o(aa),
        .req_b_i(rb), .ack_b_o(ab), .out_req_o(oreq), .out_ack_i(oack));

    opp_merge #(.ALLOW_BUNDLE(1'b0), .RR_INIT(1'b0)) u_dut_rr (
        .clk(clk), .rst_n(rst_n), .req_a_i(ra2), .ack_a_o(aa2),
        .req_b_i(rb2), .ack_b_o(ab2), .out_req_o(oreq2), .out_ack_i(oack2));

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {out_req,ack_b,ack_a} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One bundled-mode transaction; late_b raises b after out_req is high.
    task automatic run_txn(input bit pa, input bit pb, input bit late_b);
        bit sb = pb && !late_b;
        ra = pa; rb = sb;
        @(negedge clk);
        chk("R3 issue", {oreq, ab, aa}, {pa | sb, 2'b00});
        if (!(pa | sb)) return;
        if (late_b) rb = 1'b1;
        @(negedge clk);
        chk("R5 hold without ack", {oreq, ab, aa}, 3'b100);
        oack = 1'b1;
        @(negedge clk);
        chk(pa && sb ? "R2 bundle" : "R4 single ack", {oreq, ab, aa}, {1'b0, sb, pa});
        oack = 1'b0;
        @(negedge clk);
        chk("R6 ack held / R7 no reissue", {oreq, ab, aa}, {1'b0, sb, pa});
        if (pa) ra = 1'b0;
        if (sb) rb = 1'b0;
        @(negedge clk);
        chk("R6 ack clears", {oreq, ab, aa}, 3'b000);
        @(negedge clk);
        chk("R8 late request served next", {oreq, ab, aa}, {late_b, 2'b00});
        if (late_b) begin
            oack = 1'b1;
            @(negedge clk);
            chk("R8 late ack alone", {oreq, ab, aa}, 3'b010);
            oack = 1'b0; rb = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk("R6 late ack clears", {oreq, ab, aa}, 3'b000);
        end
    endtask

    // Round-robin instance: serve every pending client, one per transaction.
    task automatic run_rr(input bit pa, input bit pb);
        bit wa = pa, wb = pb;
        ra2 = pa; rb2 = pb;
        while (wa || wb) begin
            bit take_b = (wa && wb) ? rr_m : wb;
            @(negedge clk);
            chk("R9 issue", {oreq2, ab2, aa2}, 3'b100);
            oack2 = 1'b1;
            @(negedge clk);
            chk("R9 winner", {oreq2, ab2, aa2}, {1'b0, take_b, !take_b});
            rr_m = !take_b;
            oack2 = 1'b0;
            @(negedge clk);
            if (take_b) begin rb2 = 1'b0; wb = 0; end
            else        begin ra2 = 1'b0; wa = 0; end
            @(negedge clk);
            chk("R9 winner released", {oreq2, ab2, aa2}, 3'b000);
        end
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ra = 1'b1; rb = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 in reset", {oreq, ab, aa}, 3'b000);
        ra = 1'b0; rb = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {oreq, ab, aa}, 3'b000);
        chk("R1 after reset rr", {oreq2, ab2, aa2}, 3'b000);
        for (int p = 0; p < 4; p++) run_txn(p[0], p[1], 1'b0);
        run_txn(1'b1, 1'b1, 1'b1);
        for (int p = 3; p >= 0; p--) run_txn(p[0], p[1], 1'b0);
        run_rr(1'b1, 1'b1);
        run_rr(1'b1, 1'b0);
        run_rr(1'b1, 1'b1);
        run_rr(1'b0, 1'b1);
        run_rr(1'b1, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule